// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the control unit that moves a 16-bit segmented processor into and out of interrupt service routines. Whenever the instruction pipeline reports that an instruction has completed, the block checks its request lines. A request can come from an arithmetic fault, a software trap instruction carrying an 8-bit type, a non-maskable edge, or a maskable level request whose type comes from an external controller. When a request is taken, the block saves the flag word, the code segment and the instruction pointer on a stack that grows downward. It then clears the interrupt-enable and single-step flags and loads a new code segment and instruction pointer from a vector table at the bottom of memory. When the sequence ends, the new context is handed back to the fetch logic.

The block also carries out the return-from-interrupt operation. This pops the three words in reverse order, so the interrupted program resumes with its earlier enable and trap state. Stack and vector accesses go through a word-wide memory port. The read data on that port is expected in the same cycle as the request. A stack address is formed as the stack segment times 16 plus the stack pointer, wrapping at 20 bits.

Top module: `trap_seq`

## Requirements
- R1: Requests and `iret_req` are acted on only in a cycle where `boundary` is high and the block is idle (`busy` low). Otherwise they have no effect and `busy` stays low. `busy` rises in the cycle after an accepted boundary.
- R2: An entry makes exactly three word writes, one per cycle, in this order: the flag word to SS*16+SP-2, then CS to SP-4, then IP to SP-6. At completion `sp_out` equals SP-6.
- R3: After an entry, `flags_out` equals the captured flag word with bit 9 (interrupt enable) and bit 8 (single step) cleared and every other bit kept. The copy written to the stack is the unmodified flag word.
- R4: For type n, the new IP is read from byte address 4n and the new CS from 4n+2. Both appear on `ip_out` and `cs_out` when `done` pulses, six cycles after the accepted boundary cycle.
- R5: `div_err` enters with type 0. `soft_req` enters with the type given on `soft_type`.
- R6: A 0-to-1 transition on `nmi` is latched until serviced, so even a one-cycle pulse is kept. It enters with type 2 whatever bit 9 of `flags_in` holds, provided the boundary comes at least one cycle after the edge. A level held high gives only one entry.
- R7: `intr` is taken only when bit 9 of `flags_in` is set, and it enters with the type on `intr_type`. `intr_ack` is high for exactly one cycle, the first cycle of an entry caused by `intr`, and never for other sources.
- R8: The priority at a boundary is `div_err` first, then `soft_req`, then the latched NMI, then `intr`. A latched NMI that loses stays pending for a later boundary.
- R9: With `iret_req` at an accepted boundary, the block reads IP from SS*16+SP, CS from SP+2 and the flag word from SP+4. It reports them with `sp_out` equal to SP+6, and `done` pulses four cycles after the boundary cycle. The return takes precedence over interrupt requests at that boundary, and a latched NMI stays pending.
- R10: `done` is a one-cycle pulse. `busy` stays high from the cycle after the boundary through the `done` cycle. The context outputs hold their values until the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction has completed this cycle |
| iret_req | input | 1 | Completed instruction was a return-from-interrupt |
| div_err | input | 1 | Completed instruction raised a divide fault |
| soft_req | input | 1 | Completed instruction was a software trap |
| soft_type | input | 8 | Type of the software trap |
| nmi | input | 1 | Non-maskable request, edge sensitive |
| intr | input | 1 | Maskable request, level sensitive |
| intr_type | input | 8 | Type supplied with the maskable request |
| flags_in | input | 16 | Current flag word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| mem_rdata | input | 16 | Read data, valid in the request cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | New context valid, one-cycle pulse |
| intr_ack | output | 1 | Maskable request accepted |
| flags_out | output | 16 | Resulting flag word |
| cs_out | output | 16 | Resulting code segment |
| ip_out | output | 16 | Resulting instruction pointer |
| sp_out | output | 16 | Resulting stack pointer |

## Verification
The software trap is swept over all 256 types. Each type uses a different flag word, context and stack pointer, and each entry is followed by a return. A wrong vector offset or a swapped segment/offset word therefore shows up at a specific type, and a stack slot that is out of order or missing breaks the round trip. Divide faults, one-cycle and held NMI levels, and maskable requests under both enable states are then applied alone and in competing pairs. These runs separate the priority order, the edge latch, the mask and the acknowledge pulse. Requests raised without a boundary, and an NMI pending across a return, show that nothing is acted on except at an idle boundary.

// File: rtl/trap_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package trap_pkg;

    // Sequencer phases; each phase takes one clock.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_F,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_VEC_IP,
        ST_VEC_CS,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_F,
        ST_DONE
    } seq_state_t;

    // Origin of an accepted entry, listed in falling priority.
    typedef enum logic [1:0] {
        SRC_FAULT,
        SRC_SOFT,
        SRC_NMI,
        SRC_INTR
    } req_src_t;

endpackage

// File: rtl/trap_req_arb.sv
// Request arbiter: latches rising edges of the non-maskable line and,
// when the sequencer samples at an instruction boundary, chooses at most
// one action. A return wins over any request. Among requests the order is
// fault, software trap, latched NMI, then the maskable line gated by the
// enable flag. Assumes `sample` is high only at an idle boundary.
module trap_req_arb
    import trap_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int DIV_TYPE = 0,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              iret_req,
    input  logic              div_err,
    input  logic              soft_req,
    input  logic [TYPE_W-1:0] soft_type,
    input  logic              nmi,
    input  logic              intr,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic              if_flag,
    output logic              start_entry,
    output logic              start_ret,
    output logic [TYPE_W-1:0] sel_type,
    output req_src_t          sel_src
);
    localparam logic [TYPE_W-1:0] FAULT_CODE = TYPE_W'(DIV_TYPE);
    localparam logic [TYPE_W-1:0] NMI_CODE   = TYPE_W'(NMI_TYPE);

    logic nmi_q;
    logic nmi_pend;
    logic nmi_rise;
    logic any_req;
    logic take_nmi;

    assign nmi_rise = nmi & ~nmi_q;
    assign any_req  = div_err | soft_req | nmi_pend | (intr & if_flag);
    assign start_ret   = sample & iret_req;
    assign start_entry = sample & ~iret_req & any_req;
    assign take_nmi    = start_entry && (sel_src == SRC_NMI);

    // Fixed-priority choice of source and vector type.
    always_comb begin
        sel_src  = SRC_INTR;
        sel_type = intr_type;
        if (div_err) begin
            sel_src  = SRC_FAULT;
            sel_type = FAULT_CODE;
        end else if (soft_req) begin
            sel_src  = SRC_SOFT;
            sel_type = soft_type;
        end else if (nmi_pend) begin
            sel_src  = SRC_NMI;
            sel_type = NMI_CODE;
        end
    end

    // Edge detector and pending latch for the non-maskable line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi;
            nmi_pend <= (nmi_pend & ~take_nmi) | nmi_rise;
        end
    end

endmodule

// File: rtl/trap_addr_gen.sv
// Address generator: forms the physical byte address for the current
// phase. Stack phases use segment << SEG_SHIFT plus the stack pointer,
// wrapping at ADDR_W bits. Vector phases use type times the vector size,
// with the segment word one data word above the offset word.
module trap_addr_gen
    import trap_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8
) (
    input  seq_state_t        state,
    input  logic [DATA_W-1:0] ss,
    input  logic [DATA_W-1:0] sp,
    input  logic [TYPE_W-1:0] vtype,
    output logic [ADDR_W-1:0] addr
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int VEC_SHIFT  = $clog2(2 * WORD_BYTES);

    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] vec_base;

    assign stack_addr = (ADDR_W'(ss) << SEG_SHIFT) + ADDR_W'(sp);
    assign vec_base   = ADDR_W'(vtype) << VEC_SHIFT;

    // Select the address source from the phase.
    always_comb begin
        case (state)
            ST_VEC_IP: addr = vec_base;
            ST_VEC_CS: addr = vec_base + ADDR_W'(WORD_BYTES);
            default:   addr = stack_addr;
        endcase
    end

endmodule

// File: rtl/trap_ctrl.sv
// Sequencer core: captures the context at a start pulse, walks through the
// push/vector or pop phases one per clock, and holds the resulting context.
// The stack pointer register is pre-decremented for pushes and
// post-incremented for pops. Read data must be valid in the same cycle as
// the read request.
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TYPE_W = 8,
    parameter int IF_BIT = 9,
    parameter int TF_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_entry,
    input  logic              start_ret,
    input  logic [TYPE_W-1:0] sel_type,
    input  req_src_t          sel_src,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] cs_in,
    input  logic [DATA_W-1:0] ip_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] ss_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output seq_state_t        state,
    output logic [DATA_W-1:0] ss_r,
    output logic [DATA_W-1:0] sp_r,
    output logic [TYPE_W-1:0] type_r,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              intr_ack,
    output logic [DATA_W-1:0] flags_r,
    output logic [DATA_W-1:0] cs_r,
    output logic [DATA_W-1:0] ip_r
);
    localparam logic [DATA_W-1:0] STEP     = DATA_W'(DATA_W / 8);
    localparam logic [DATA_W-1:0] CLR_MASK = (DATA_W'(1) << IF_BIT) | (DATA_W'(1) << TF_BIT);

    req_src_t src_r;

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign intr_ack = (state == ST_PUSH_F) && (src_r == SRC_INTR);

    // Decode memory strobes and write data from the phase.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_F: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = flags_r;
            end
            ST_PUSH_CS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = cs_r;
            end
            ST_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ip_r;
            end
            ST_VEC_IP, ST_VEC_CS, ST_POP_IP, ST_POP_CS, ST_POP_F: mem_req = 1'b1;
            default: ;
        endcase
    end

    // Phase sequencing and context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            src_r   <= SRC_FAULT;
            type_r  <= '0;
            ss_r    <= '0;
            sp_r    <= '0;
            flags_r <= '0;
            cs_r    <= '0;
            ip_r    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_entry) begin
                        state   <= ST_PUSH_F;
                        src_r   <= sel_src;
                        type_r  <= sel_type;
                        ss_r    <= ss_in;
                        sp_r    <= sp_in - STEP;
                        flags_r <= flags_in;
                        cs_r    <= cs_in;
                        ip_r    <= ip_in;
                    end else if (start_ret) begin
                        state <= ST_POP_IP;
                        ss_r  <= ss_in;
                        sp_r  <= sp_in;
                    end
                end
                ST_PUSH_F: begin
                    sp_r    <= sp_r - STEP;
                    flags_r <= flags_r & ~CLR_MASK;
                    state   <= ST_PUSH_CS;
                end
                ST_PUSH_CS: begin
                    sp_r  <= sp_r - STEP;
                    state <= ST_PUSH_IP;
                end
                ST_PUSH_IP: state <= ST_VEC_IP;
                ST_VEC_IP: begin
                    ip_r  <= mem_rdata;
                    state <= ST_VEC_CS;
                end
                ST_VEC_CS: begin
                    cs_r  <= mem_rdata;
                    state <= ST_DONE;
                end
                ST_POP_IP: begin
                    ip_r  <= mem_rdata;
                    sp_r  <= sp_r + STEP;
                    state <= ST_POP_CS;
                end
                ST_POP_CS: begin
                    cs_r  <= mem_rdata;
                    sp_r  <= sp_r + STEP;
                    state <= ST_POP_F;
                end
                ST_POP_F: begin
                    flags_r <= mem_rdata;
                    sp_r    <= sp_r + STEP;
                    state   <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/trap_seq.sv
// Top of the interrupt entry/return sequencer. Joins the request arbiter,
// the sequencer core and the address generator. Sampling happens only when
// the core is idle and the pipeline flags an instruction boundary.
module trap_seq
    import trap_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 20,
    parameter int SEG_SHIFT = 4,
    parameter int TYPE_W    = 8,
    parameter int IF_BIT    = 9,
    parameter int TF_BIT    = 8,
    parameter int DIV_TYPE  = 0,
    parameter int NMI_TYPE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              iret_req,
    input  logic              div_err,
    input  logic              soft_req,
    input  logic [TYPE_W-1:0] soft_type,
    input  logic              nmi,
    input  logic              intr,
    input  logic [TYPE_W-1:0] intr_type,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] cs_in,
    input  logic [DATA_W-1:0] ip_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] ss_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              intr_ack,
    output logic [DATA_W-1:0] flags_out,
    output logic [DATA_W-1:0] cs_out,
    output logic [DATA_W-1:0] ip_out,
    output logic [DATA_W-1:0] sp_out
);
    seq_state_t        state;
    logic              sample;
    logic              start_entry;
    logic              start_ret;
    logic [TYPE_W-1:0] sel_type;
    req_src_t          sel_src;
    logic [DATA_W-1:0] ss_r;
    logic [TYPE_W-1:0] type_r;

    assign sample = boundary && (state == ST_IDLE);

    trap_req_arb #(
        .TYPE_W  (TYPE_W),
        .DIV_TYPE(DIV_TYPE),
        .NMI_TYPE(NMI_TYPE)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (sample),
        .iret_req   (iret_req),
        .div_err    (div_err),
        .soft_req   (soft_req),
        .soft_type  (soft_type),
        .nmi        (nmi),
        .intr       (intr),
        .intr_type  (intr_type),
        .if_flag    (flags_in[IF_BIT]),
        .start_entry(start_entry),
        .start_ret  (start_ret),
        .sel_type   (sel_type),
        .sel_src    (sel_src)
    );

    trap_ctrl #(
        .DATA_W(DATA_W),
        .TYPE_W(TYPE_W),
        .IF_BIT(IF_BIT),
        .TF_BIT(TF_BIT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_entry(start_entry),
        .start_ret  (start_ret),
        .sel_type   (sel_type),
        .sel_src    (sel_src),
        .flags_in   (flags_in),
        .cs_in      (cs_in),
        .ip_in      (ip_in),
        .sp_in      (sp_in),
        .ss_in      (ss_in),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .ss_r       (ss_r),
        .sp_r       (sp_out),
        .type_r     (type_r),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .busy       (busy),
        .done       (done),
        .intr_ack   (intr_ack),
        .flags_r    (flags_out),
        .cs_r       (cs_out),
        .ip_r       (ip_out)
    );

    trap_addr_gen #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .SEG_SHIFT(SEG_SHIFT),
        .TYPE_W   (TYPE_W)
    ) u_addr (
        .state(state),
        .ss   (ss_r),
        .sp   (sp_out),
        .vtype(type_r),
        .addr (mem_addr)
    );

endmodule

// File: rtl/trap_seq_chk.sv
// Property checker for trap_seq, attached with bind. Watches only the
// top-level ports.
module trap_seq_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 20,
    parameter int TYPE_W = 8,
    parameter int IF_BIT = 9,
    parameter int TF_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] flags_out,
    input logic              intr_ack
);
    localparam int              WORD_BYTES = DATA_W / 8;
    localparam int              VEC_SHIFT  = $clog2(2 * WORD_BYTES);
    localparam logic [ADDR_W-1:0] VEC_TOP  = ADDR_W'(1) << (TYPE_W + VEC_SHIFT);

    // R1: no memory traffic while idle
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R2: consecutive pushes step down by one word
    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |->
        (mem_addr == $past(mem_addr) - ADDR_W'(WORD_BYTES)));

    // R3: an entry ends with both flag bits cleared
    a_r3_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(mem_we, 3)) |-> (!flags_out[IF_BIT] && !flags_out[TF_BIT]));

    // R4: the first read after the pushes is an aligned vector slot
    a_r4_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req && mem_we)) |->
        (mem_addr[VEC_SHIFT-1:0] == '0 && mem_addr < VEC_TOP));

    // R7: acknowledge is a single-cycle pulse
    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack |=> !intr_ack);

    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: busy only drops right after done
    a_r10_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

bind trap_seq trap_seq_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .TYPE_W(TYPE_W),
    .IF_BIT(IF_BIT),
    .TF_BIT(TF_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .flags_out(flags_out),
    .intr_ack (intr_ack)
);

// File: tb/sim_trap_seq.sv
`timescale 1ns/1ps
module sim_trap_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0, iret_req = 1'b0, div_err = 1'b0, soft_req = 1'b0;
    logic [7:0]  soft_type = '0, intr_type = '0;
    logic        nmi = 1'b0, intr = 1'b0;
    logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, sp_in = '0;
    logic [15:0] ss_in = 16'h0080;
    logic [15:0] mem_rdata;
    logic        mem_req, mem_we, busy, done, intr_ack;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, flags_out, cs_out, ip_out, sp_out;

    int checks = 0;
    int failures = 0;
    int wcount = 0;
    logic [19:0] wlog_a [0:15];
    logic [15:0] wlog_d [0:15];
    logic [15:0] mem [0:4095];

    always #2 clk = ~clk;

    trap_seq u0 (.*);

    // Memory model: combinational read, write on the clock edge, write log.
    assign mem_rdata = mem[mem_addr[12:1]];
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[12:1]] <= mem_wdata;
            wlog_a[wcount % 16] <= mem_addr;
            wlog_d[wcount % 16] <= mem_wdata;
            wcount <= wcount + 1;
        end
    end

    function automatic logic [15:0] vip(input logic [7:0] n);
        return 16'h1000 + 16'(n) * 16'd7;
    endfunction
    function automatic logic [15:0] vcs(input logic [7:0] n);
        return 16'hC000 ^ (16'(n) << 4);
    endfunction
    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] p);
        return (20'(s) << 4) + 20'(p);
    endfunction

    task automatic ceq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_entry(input logic d, input logic s, input logic [7:0] st,
                             input logic i, input logic [7:0] it,
                             input logic [15:0] f, input logic [15:0] c,
                             input logic [15:0] p, input logic [15:0] spv,
                             input logic [7:0] et, input logic eack);
        int wb;
        logic [19:0] base;
        @(negedge clk);
        flags_in = f; cs_in = c; ip_in = p; sp_in = spv;
        div_err = d; soft_req = s; soft_type = st; intr = i; intr_type = it;
        boundary = 1'b1;
        wb = wcount;
        @(negedge clk);
        boundary = 1'b0; div_err = 1'b0; soft_req = 1'b0; intr = 1'b0;
        ceq("R1 busy after accepted boundary", busy, 1);
        ceq($sformatf("R7 intr_ack type %0d", et), intr_ack, eack);
        repeat (4) @(negedge clk);
        ceq("R4 done not before sixth cycle", done, 0);
        @(negedge clk);
        ceq("R10 done pulse", done, 1);
        ceq($sformatf("R4 R5 new IP type %0d", et), ip_out, vip(et));
        ceq($sformatf("R4 R5 new CS type %0d", et), cs_out, vcs(et));
        ceq("R3 flags with IF and TF cleared", flags_out, f & ~16'h0300);
        ceq("R2 final stack pointer", sp_out, spv - 16'd6);
        ceq("R2 three writes", wcount - wb, 3);
        base = phys(ss_in, spv);
        ceq("R2 flags slot address", wlog_a[wb % 16], base - 20'd2);
        ceq("R3 stacked flags unmodified", wlog_d[wb % 16], f);
        ceq("R2 CS slot address", wlog_a[(wb + 1) % 16], base - 20'd4);
        ceq("R2 CS slot data", wlog_d[(wb + 1) % 16], c);
        ceq("R2 IP slot address", wlog_a[(wb + 2) % 16], base - 20'd6);
        ceq("R2 IP slot data", wlog_d[(wb + 2) % 16], p);
        @(negedge clk);
        ceq("R10 busy low after done", busy, 0);
        ceq("R10 IP held after done", ip_out, vip(et));
    endtask

    task automatic run_iret(input logic [15:0] f, input logic [15:0] c,
                            input logic [15:0] p, input logic [15:0] spv);
        @(negedge clk);
        sp_in = spv - 16'd6; flags_in = 16'h0000;
        iret_req = 1'b1; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0; iret_req = 1'b0;
        ceq("R9 busy after return boundary", busy, 1);
        repeat (2) @(negedge clk);
        ceq("R9 done not before fourth cycle", done, 0);
        @(negedge clk);
        ceq("R9 done pulse", done, 1);
        ceq("R9 restored IP", ip_out, p);
        ceq("R9 restored CS", cs_out, c);
        ceq("R9 restored flags", flags_out, f);
        ceq("R9 restored stack pointer", sp_out, spv);
        @(negedge clk);
    endtask

    task automatic expect_idle(input logic i, input logic [15:0] f, input string req);
        @(negedge clk);
        flags_in = f; intr = i; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0; intr = 1'b0;
        ceq({req, " no sequence started"}, busy, 0);
        ceq({req, " no memory access"}, mem_req, 0);
    endtask

    task automatic pulse_nmi();
        @(negedge clk);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int n = 0; n < 256; n++) begin
            mem[2 * n]     = vip(8'(n));
            mem[2 * n + 1] = vcs(8'(n));
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ceq("R10 reset busy", busy, 0);
        ceq("R10 reset done", done, 0);
        ceq("R1 reset mem_req", mem_req, 0);

        // R5 R9 sweep: every software type, then a return.
        for (int n = 0; n < 256; n++) begin
            logic [15:0] f, c, p, s;
            f = {8'(n), ~8'(n)};
            c = 16'h3000 + 16'(n);
            p = 16'h0100 + 16'(n) * 16'd3;
            s = 16'h0800 + 16'(n) * 16'd2;
            run_entry(1'b0, 1'b1, 8'(n), 1'b0, 8'h00, f, c, p, s, 8'(n), 1'b0);
            run_iret(f, c, p, s);
        end

        // R1: requests without a boundary are ignored.
        @(negedge clk);
        div_err = 1'b1; soft_req = 1'b1; soft_type = 8'h33; intr = 1'b1;
        flags_in = 16'h0200;
        repeat (3) begin
            @(negedge clk);
            ceq("R1 no boundary no action", busy, 0);
        end
        div_err = 1'b0; soft_req = 1'b0; intr = 1'b0;

        // R5 R8: divide fault alone and against a software trap.
        run_entry(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0302, 16'h1111, 16'h2222, 16'h0900, 8'd0, 1'b0);
        run_entry(1'b1, 1'b1, 8'h44, 1'b0, 8'h00, 16'h0346, 16'h1212, 16'h3434, 16'h0910, 8'd0, 1'b0);

        // R6: short pulse latched, taken with IF clear.
        pulse_nmi();
        repeat (3) begin
            @(negedge clk);
            ceq("R6 pulse alone starts nothing", busy, 0);
        end
        run_entry(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0100, 16'h5555, 16'h6666, 16'h0920, 8'd2, 1'b0);
        // R6: held level gives one entry only.
        @(negedge clk);
        nmi = 1'b1;
        run_entry(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0000, 16'h5656, 16'h6767, 16'h0930, 8'd2, 1'b0);
        expect_idle(1'b0, 16'h0000, "R6 held NMI");
        nmi = 1'b0;

        // R7: masked INTR, then enabled INTR.
        expect_idle(1'b1, 16'h0100, "R7 INTR masked");
        run_entry(1'b0, 1'b0, 8'h00, 1'b1, 8'h41, 16'h0281, 16'h7777, 16'h8888, 16'h0940, 8'h41, 1'b1);

        // R8: NMI beats INTR; INTR taken at the next boundary.
        pulse_nmi();
        run_entry(1'b0, 1'b0, 8'h00, 1'b1, 8'h52, 16'h0200, 16'h9999, 16'hAAAA, 16'h0950, 8'd2, 1'b0);
        run_entry(1'b0, 1'b0, 8'h00, 1'b1, 8'h52, 16'h0200, 16'h9A9A, 16'hABAB, 16'h0960, 8'h52, 1'b1);

        // R8: software trap beats NMI, NMI kept pending.
        pulse_nmi();
        run_entry(1'b0, 1'b1, 8'h21, 1'b0, 8'h00, 16'h0001, 16'hBBBB, 16'hCCCC, 16'h0970, 8'h21, 1'b0);
        run_entry(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0001, 16'hBCBC, 16'hCDCD, 16'h0980, 8'd2, 1'b0);

        // R9: return beats a pending NMI, which is kept.
        run_entry(1'b0, 1'b1, 8'h10, 1'b0, 8'h00, 16'h0387, 16'hDDDD, 16'hEEEE, 16'h0990, 8'h10, 1'b0);
        pulse_nmi();
        run_iret(16'h0387, 16'hDDDD, 16'hEEEE, 16'h0990);
        run_entry(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 16'h0387, 16'hDEDE, 16'hEFEF, 16'h09A0, 8'd2, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule